// File: doc/BRIEF.md
# Link-side PHY status receiver

This block sits on the link side of a two-bit PHY-to-link interface. Every clock it samples a two-bit control code and a two-bit data lane. While the control code reads "status", the lane carries two bits of a 16-bit status image. The image holds four event flags, a four-bit register address and an eight-bit register value.

When the control code leaves the status state, the block closes the transfer and publishes the result in the next cycle. It raises one-cycle pulses for the event flags that arrived set. It classifies the transfer by its length. If the whole image arrived, it also issues a register-read strobe with the address and the value.

A transfer can be cut short by a receive indication on any cycle. Flags that arrived before the cut are still reported. A register value is published only when all eight of its bits were seen. A status cycle that arrives without an idle cycle before it is a protocol error. It sets a sticky error flag and starts a fresh transfer.

Top module: `phy_stat_rx`

## Requirements
- R1: After reset, `flag_o`, `end_o`, `kind_o`, `reg_valid_o`, `reg_addr_o`, `reg_data_o` and `err_o` are all zero.
- R2: The control code is decoded as 00 idle, 01 status, 10 receive and 11 reserved. In the k-th status cycle of a transfer (k counted from 0), `d_i[0]` carries image bit 2k and `d_i[1]` carries image bit 2k+1.
- R3: When a transfer closes, `flag_o[i]` pulses for one cycle for each flag bit i (0..3) that was received as 1. The flag bits are: 0 arbitration-reset gap, 1 subaction gap, 2 bus reset, 3 PHY interrupt.
- R4: Closing a transfer gives a one-cycle `end_o` pulse with a length class on `kind_o`: 00 for exactly 2 status cycles, 01 for exactly 8, 10 for any other length. All outputs of a close appear in the cycle after the clock edge that sampled the closing condition.
- R5: A transfer of 8 status cycles also pulses `reg_valid_o`, with `reg_addr_o[j]` = image bit 4+j and `reg_data_o[j]` = image bit 8+j.
- R6: A truncated transfer (1, 3, 4, 5, 6 or 7 cycles) reports the flags it received. Flag bits that did not arrive read as 0. No `reg_valid_o` is issued for it.
- R7: `reg_addr_o` and `reg_data_o` keep their last published values between `reg_valid_o` pulses.
- R8: A status cycle is an error when the previous cycle was not idle. This covers a status cycle right after receive or reserved, and a ninth consecutive status cycle. Such a cycle sets `err_o`, which stays set until reset. The cycle then starts a new transfer as its cycle 0, and a transfer already holding 8 cycles is published first.
- R9: Idle, receive and reserved codes each close an open transfer in the same way.
- R10: Non-status cycles while no transfer is open produce no `end_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctl_i | input | 2 | Control code from the PHY |
| d_i | input | 2 | Data lane from the PHY |
| flag_o | output | 4 | Flag pulses, one per event flag |
| end_o | output | 1 | Transfer-closed pulse |
| kind_o | output | 2 | Length class of the closed transfer |
| reg_valid_o | output | 1 | Register-read result strobe |
| reg_addr_o | output | 4 | Address of the last complete register read |
| reg_data_o | output | 8 | Value of the last complete register read |
| err_o | output | 1 | Sticky protocol-error flag |

## Verification
The bench uses the default parameters: two-bit lanes, four flags, a four-bit address and an eight-bit value, which gives an 8-cycle maximum transfer. At this size it can sweep every transfer length from 1 to 8. Each length is closed by each of the three non-status codes and driven with sixteen arithmetically derived images. The two error paths are each reached after a fresh reset: a ninth back-to-back status cycle, and a status cycle right after receive.

// File: rtl/phy_stat_pkg.sv
package phy_stat_pkg;

  typedef enum logic [1:0] {
    CTL_IDLE = 2'b00,
    CTL_STAT = 2'b01,
    CTL_RECV = 2'b10,
    CTL_RSVD = 2'b11
  } ctl_e;

  localparam logic [1:0] KIND_FLAGS = 2'b00;
  localparam logic [1:0] KIND_FULL  = 2'b01;
  localparam logic [1:0] KIND_CUT   = 2'b10;

endpackage

// File: rtl/phy_stat_dec.sv
module phy_stat_dec
  import phy_stat_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] ctl_i,
  input  logic       active_i,
  input  logic       full_i,
  output logic       load_o,
  output logic       append_o,
  output logic       finish_o,
  output logic       err_evt_o
);

  logic prev_idle_q;
  logic is_stat;

  assign is_stat = (ctl_e'(ctl_i) == CTL_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_idle_q <= 1'b1;
    else         prev_idle_q <= (ctl_e'(ctl_i) == CTL_IDLE);
  end

  // new transfer: first status, or status overrunning a full image
  assign load_o    = is_stat && (!active_i || full_i);
  assign append_o  = is_stat && active_i && !full_i;
  assign finish_o  = active_i && (!is_stat || full_i);
  assign err_evt_o = is_stat && ((active_i && full_i) || (!active_i && !prev_idle_q));

  AST_LOAD_APPEND_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_o && append_o)); // R2

  AST_ERR_ONLY_ON_STAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_evt_o |-> load_o); // R8

endmodule

// File: rtl/phy_stat_asm.sv
module phy_stat_asm #(
  parameter int STAT_W   = 16,
  parameter int LANE_W   = 2,
  parameter int FULL_CYC = STAT_W / LANE_W,
  parameter int CNT_W    = $clog2(FULL_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              append_i,
  input  logic              finish_i,
  input  logic [LANE_W-1:0] d_i,
  output logic [STAT_W-1:0] img_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              active_o,
  output logic              full_o
);

  logic [STAT_W-1:0] img_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      img_q <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (load_i) begin
      img_q <= {{(STAT_W-LANE_W){1'b0}}, d_i};
      cnt_q <= CNT_W'(1);
      act_q <= 1'b1;
    end else if (append_i) begin
      for (int j = 1; j < FULL_CYC; j++) begin
        if (cnt_q == CNT_W'(j)) img_q[j*LANE_W +: LANE_W] <= d_i;
      end
      cnt_q <= cnt_q + CNT_W'(1);
    end else if (finish_i) begin
      act_q <= 1'b0;
    end
  end

  assign img_o    = img_q;
  assign cnt_o    = cnt_q;
  assign active_o = act_q;
  assign full_o   = (cnt_q == CNT_W'(FULL_CYC));

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(FULL_CYC)); // R4

  AST_ACTIVE_HAS_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> (cnt_q != '0)); // R2

endmodule

// File: rtl/phy_stat_pub.sv
module phy_stat_pub
  import phy_stat_pkg::*;
#(
  parameter int FLAG_W   = 4,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int LANE_W   = 2,
  parameter int STAT_W   = FLAG_W + ADDR_W + DATA_W,
  parameter int FULL_CYC = STAT_W / LANE_W,
  parameter int FLAG_CYC = FLAG_W / LANE_W,
  parameter int CNT_W    = $clog2(FULL_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              finish_i,
  input  logic              err_evt_i,
  input  logic [STAT_W-1:0] img_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [FLAG_W-1:0] flag_o,
  output logic              end_o,
  output logic [1:0]        kind_o,
  output logic              reg_valid_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_data_o,
  output logic              err_o
);

  logic [FLAG_W-1:0] flag_seen;
  logic              is_full;
  logic [1:0]        kind_d;

  // a flag counts only if its lane arrived
  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
    localparam int NEED = i / LANE_W + 1;
    assign flag_seen[i] = img_i[i] && (cnt_i >= CNT_W'(NEED));
  end

  assign is_full = (cnt_i == CNT_W'(FULL_CYC));

  always_comb begin
    if (is_full)                        kind_d = KIND_FULL;
    else if (cnt_i == CNT_W'(FLAG_CYC)) kind_d = KIND_FLAGS;
    else                                kind_d = KIND_CUT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o      <= '0;
      end_o       <= 1'b0;
      kind_o      <= '0;
      reg_valid_o <= 1'b0;
      reg_addr_o  <= '0;
      reg_data_o  <= '0;
      err_o       <= 1'b0;
    end else begin
      flag_o      <= finish_i ? flag_seen : '0;
      end_o       <= finish_i;
      kind_o      <= finish_i ? kind_d : '0;
      reg_valid_o <= finish_i && is_full;
      if (finish_i && is_full) begin
        reg_addr_o <= img_i[FLAG_W +: ADDR_W];
        reg_data_o <= img_i[FLAG_W+ADDR_W +: DATA_W];
      end
      if (err_evt_i) err_o <= 1'b1;
    end
  end

  AST_FLAG_WITH_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|flag_o) |-> end_o); // R3

  AST_REG_ONLY_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_valid_o |-> (end_o && kind_o == KIND_FULL)); // R5

  AST_REG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_valid_o |-> ($stable(reg_addr_o) && $stable(reg_data_o))); // R7

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R8

endmodule

// File: rtl/phy_stat_rx.sv
module phy_stat_rx
  import phy_stat_pkg::*;
#(
  parameter int FLAG_W = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int LANE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        ctl_i,
  input  logic [LANE_W-1:0] d_i,
  output logic [FLAG_W-1:0] flag_o,
  output logic              end_o,
  output logic [1:0]        kind_o,
  output logic              reg_valid_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_data_o,
  output logic              err_o
);

  localparam int STAT_W   = FLAG_W + ADDR_W + DATA_W;
  localparam int FULL_CYC = STAT_W / LANE_W;
  localparam int CNT_W    = $clog2(FULL_CYC + 1);

  logic              load, append, finish, err_evt;
  logic              active, full;
  logic [STAT_W-1:0] img;
  logic [CNT_W-1:0]  cnt;

  phy_stat_dec u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctl_i     (ctl_i),
    .active_i  (active),
    .full_i    (full),
    .load_o    (load),
    .append_o  (append),
    .finish_o  (finish),
    .err_evt_o (err_evt)
  );

  phy_stat_asm #(
    .STAT_W (STAT_W),
    .LANE_W (LANE_W)
  ) u_asm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .append_i (append),
    .finish_i (finish),
    .d_i      (d_i),
    .img_o    (img),
    .cnt_o    (cnt),
    .active_o (active),
    .full_o   (full)
  );

  phy_stat_pub #(
    .FLAG_W (FLAG_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LANE_W (LANE_W)
  ) u_pub (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .finish_i    (finish),
    .err_evt_i   (err_evt),
    .img_i       (img),
    .cnt_i       (cnt),
    .flag_o      (flag_o),
    .end_o       (end_o),
    .kind_o      (kind_o),
    .reg_valid_o (reg_valid_o),
    .reg_addr_o  (reg_addr_o),
    .reg_data_o  (reg_data_o),
    .err_o       (err_o)
  );

  AST_STAT_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_e'(ctl_i) == CTL_STAT) |=> active); // R2

  AST_NONSTAT_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_e'(ctl_i) != CTL_STAT) |=> !active); // R9

  AST_QUIET_NO_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active && ctl_e'(ctl_i) != CTL_STAT) |=> !end_o); // R10

endmodule

// File: tb/tb_phy_stat_rx.sv
module tb_phy_stat_rx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ctl = 2'b00;
  logic [1:0] d = 2'b00;
  logic [3:0] flag;
  logic       end_p, reg_valid, err;
  logic [1:0] kind;
  logic [3:0] reg_addr;
  logic [7:0] reg_data;

  int tests = 0;
  int fails = 0;
  logic [3:0] exp_addr = '0;
  logic [7:0] exp_data = '0;

  always #5 clk = ~clk;

  phy_stat_rx dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .ctl_i       (ctl),
    .d_i         (d),
    .flag_o      (flag),
    .end_o       (end_p),
    .kind_o      (kind),
    .reg_valid_o (reg_valid),
    .reg_addr_o  (reg_addr),
    .reg_data_o  (reg_data),
    .err_o       (err)
  );

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    ctl = 2'b00; d = 2'b00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    exp_addr = '0; exp_data = '0;
  endtask

  // drive len status cycles, close with endc, check the published result
  task automatic run_xfer(int len, logic [15:0] img, logic [1:0] endc);
    logic [3:0] mask;
    logic [1:0] ek;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      ctl = 2'b01;
      d = img[2*k +: 2];
    end
    @(negedge clk);
    ctl = endc; d = 2'b11;
    @(negedge clk);
    mask = (len == 1) ? 4'b0011 : 4'b1111;
    ek = (len == 2) ? 2'b00 : (len == 8) ? 2'b01 : 2'b10;
    if (len == 8) begin
      exp_addr = img[7:4];
      exp_data = img[15:8];
    end
    chk("R4 end", int'(end_p), 1);
    chk("R4 kind", int'(kind), int'(ek));
    chk("R3/R6 flags", int'(flag), int'(img[3:0] & mask));
    chk("R5/R6 reg_valid", int'(reg_valid), (len == 8) ? 1 : 0);
    chk("R5/R7 reg_addr", int'(reg_addr), int'(exp_addr));
    chk("R5/R7 reg_data", int'(reg_data), int'(exp_data));
    ctl = 2'b00; d = 2'b00;
    @(negedge clk);
    chk("R10 no end while idle", int'(end_p), 0);
    chk("R3 flag pulse width", int'(flag), 0);
  endtask

  initial begin
    logic [1:0] endc;
    do_reset();
    // R1
    chk("R1 flag", int'(flag), 0);
    chk("R1 end", int'(end_p), 0);
    chk("R1 kind", int'(kind), 0);
    chk("R1 reg_valid", int'(reg_valid), 0);
    chk("R1 reg_addr", int'(reg_addr), 0);
    chk("R1 reg_data", int'(reg_data), 0);
    chk("R1 err", int'(err), 0);

    // R2 R9: every length, every closing code, sixteen images
    for (int len = 1; len <= 8; len++) begin
      for (int ec = 0; ec < 3; ec++) begin
        endc = (ec == 0) ? 2'b00 : (ec == 1) ? 2'b10 : 2'b11;
        for (int p = 0; p < 16; p++) begin
          run_xfer(len, 16'(p * 40503) ^ 16'(len << 11) ^ 16'(ec * 4369), endc);
        end
      end
    end
    chk("R8 no error on clean traffic", int'(err), 0);

    // R8: ninth consecutive status cycle
    do_reset();
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      ctl = 2'b01;
      d = 16'hA5C3 >> (2*k);
    end
    @(negedge clk);
    d = 2'b11;
    @(negedge clk);
    ctl = 2'b00; d = 2'b00;
    chk("R8 overrun publishes full end", int'(end_p), 1);
    chk("R8 overrun kind", int'(kind), 1);
    chk("R8 overrun reg_valid", int'(reg_valid), 1);
    chk("R8 overrun reg_addr", int'(reg_addr), 4'hC);
    chk("R8 overrun reg_data", int'(reg_data), 8'hA5);
    chk("R8 overrun flags", int'(flag), 4'h3);
    chk("R8 err set", int'(err), 1);
    @(negedge clk);
    chk("R8 restarted transfer end", int'(end_p), 1);
    chk("R8 restarted kind", int'(kind), 2);
    chk("R8 restarted flags", int'(flag), 4'h3);
    chk("R8 restarted no reg_valid", int'(reg_valid), 0);
    repeat (3) @(negedge clk);
    chk("R8 err sticky", int'(err), 1);

    // R8 R10: status right after receive
    do_reset();
    ctl = 2'b10;
    @(negedge clk);
    chk("R10 receive without transfer", int'(end_p), 0);
    ctl = 2'b01; d = 2'b01;
    @(negedge clk);
    d = 2'b10;
    @(negedge clk);
    ctl = 2'b00; d = 2'b00;
    chk("R8 err after receive", int'(err), 1);
    @(negedge clk);
    chk("R8 transfer kept end", int'(end_p), 1);
    chk("R8 transfer kept kind", int'(kind), 0);
    chk("R8 transfer kept flags", int'(flag), 4'h9);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule